// File: doc/BRIEF.md
# Event Timer Register Bank and Main Counter

This block is the register front end of a three-channel event timer. It holds the global configuration, a capability word and a 64-bit free-running main counter. It is reached through a 32-bit word-addressed interface that covers a 1 KiB window. The main counter advances by one on every pulse of a tick-enable input, but only while the global enable bit is set.

Each channel owns a 32-byte window in the upper three quarters of the address space. The block decodes those windows. It forwards channel writes as single-cycle strobes with a shared data bus, and it reads back the channel state that the channel logic presents on input ports. When the global enable bit goes from 0 to 1, the block sends a one-cycle re-arm pulse to each channel whose comparator is not all ones.

Top module: `evtmr_regs`

## Requirements
- R1: After reset, the read data, the main counter, both global configuration outputs, every channel strobe and every re-arm pulse are zero.
- R2: A read of word 0x000 returns the capability word 0x8086A201. A read of word 0x004 returns the tick period, 10,000,000 fs (0x00989680). Writes to either word change nothing.
- R3: At 0x010, bit 0 is the global enable and bit 1 is the legacy-route flag. They are the only writable configuration bits. A read returns them in those positions with every other bit zero, and a read of 0x014 returns zero. The outputs `glb_enable` and `glb_legacy` follow the two bits.
- R4: When enable is set and `tick` is high in a cycle with no counter write, the main counter increases by exactly one. Otherwise it holds its value.
- R5: A write to 0x0F0 replaces bits 31:0 of the counter, and a write to 0x0F4 replaces bits 63:32. The other half is kept. A counter write takes precedence over a tick in the same cycle.
- R6: A read of 0x0F0 returns counter bits 31:0 and captures bits 63:32 in the same cycle. A later read of 0x0F4 returns that captured value.
- R7: A configuration write that sets enable while it was clear raises `ch_rearm[i]` for one cycle, in the cycle after the write, for each channel whose 64-bit comparator input is not all ones. No pulse appears in any other case.
- R8: Channel i owns bytes 0x100+0x20*i to 0x11F+0x20*i. A write at byte offset 0x00 in that window asserts `ch_cfg_we[i]`, at 0x08 asserts `ch_cmp_lo_we[i]`, and at 0x0C asserts `ch_cmp_hi_we[i]`. Each strobe is asserted combinationally in the same cycle as `bus_wr`, with `ch_wdata` equal to `bus_wdata`. Writes at any other offset raise no strobe.
- R9: Channel read offsets map as follows: 0x00 to configuration, 0x04 to capabilities, 0x08 and 0x0C to the low and high comparator halves, and 0x10 to the route word. Other offsets read as zero. A channel index of 3 or more reads as zero and raises no strobe.
- R10: Writes to the status word at 0x020 have no effect. The status word and every unmapped global address read as zero.
- R11: `bus_rdata` is registered. It takes the read value in the cycle after `bus_rd` and holds that value until the next read. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter tick-enable pulse |
| bus_wr | input | 1 | Word write request |
| bus_rd | input | 1 | Word read request |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| counter_val | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy-route bit |
| ch_wdata | output | 32 | Data for channel writes |
| ch_cfg_we | output | 3 | Channel configuration write strobes |
| ch_cmp_lo_we | output | 3 | Comparator low-half write strobes |
| ch_cmp_hi_we | output | 3 | Comparator high-half write strobes |
| ch_rearm | output | 3 | Re-arm pulses on enable rising |
| ch_cfg_in | input | 96 | Channel configuration read-back, 32 bits per channel |
| ch_cap_in | input | 96 | Channel capability read-back |
| ch_cmp_in | input | 192 | Channel comparator read-back, 64 bits per channel |
| ch_route_in | input | 96 | Channel route read-back |

## Verification
The main counter is visible at the ports in every cycle. A wrong step, a missed hold or a corrupted half therefore shows on `counter_val` one clock after the cause, and it persists. A stale enable bit shows both on `glb_enable` and in the next counter step. A broken capture register stays hidden until the next read of the high half, so the stimulus pairs low and high reads while the counter carries across the 32-bit boundary. Decode faults show on the strobes in the same cycle and on read data one cycle later, because every slot and offset is swept, including slots that exist only in the address map.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int WIN_AW = 10;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CAP_LO,
        RG_CAP_HI,
        RG_CFG,
        RG_STAT,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_CH_CFG,
        RG_CH_CAP,
        RG_CH_CMP_LO,
        RG_CH_CMP_HI,
        RG_CH_ROUTE
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [4:0] slot;
    } dec_t;

endpackage

// File: rtl/evtmr_decode.sv
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [WIN_AW-1:0] addr,
    output dec_t              dec
);
    localparam logic [4:0] NCH_W = 5'(NCH);

    always_comb begin
        dec.region = RG_NONE;
        dec.slot   = '0;
        if (addr[9:8] != 2'b00) begin
            // channel area: 32-byte slots starting at 0x100
            dec.slot = addr[9:5] - 5'd8;
            if (dec.slot < NCH_W) begin
                case (addr[4:2])
                    3'd0:    dec.region = RG_CH_CFG;
                    3'd1:    dec.region = RG_CH_CAP;
                    3'd2:    dec.region = RG_CH_CMP_LO;
                    3'd3:    dec.region = RG_CH_CMP_HI;
                    3'd4:    dec.region = RG_CH_ROUTE;
                    default: dec.region = RG_NONE;
                endcase
            end
        end else begin
            case (addr[7:2])
                6'h00:   dec.region = RG_CAP_LO;
                6'h01:   dec.region = RG_CAP_HI;
                6'h04:   dec.region = RG_CFG;
                6'h08:   dec.region = RG_STAT;
                6'h3C:   dec.region = RG_CNT_LO;
                6'h3D:   dec.region = RG_CNT_HI;
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
    parameter int CW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [CW/2-1:0] wdata,
    input  logic            snap,
    output logic [CW-1:0]   count,
    output logic [CW/2-1:0] hi_snap
);
    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [HW-1:0] snap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo)
            st_d.cnt[HW-1:0] = wdata;
        else if (wr_hi)
            st_d.cnt[CW-1:HW] = wdata;
        else if (run && tick)
            st_d.cnt = st_q.cnt + 1'b1;
        if (snap)
            st_d.snap = st_q.cnt[CW-1:HW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign hi_snap = st_q.snap;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && !(run && tick)) |=> $stable(count));
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && run && tick) |=> (count == $past(count) + 1'b1));
    // R5
    cnt_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[CW-1:HW] == $past(count[CW-1:HW])));
    // R6
    cnt_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (hi_snap == $past(count[CW-1:HW])));
endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
    import evtmr_pkg::*;
#(
    parameter int          NCH     = 3,
    parameter int          DW      = 32,
    parameter logic [15:0] VENDOR  = 16'h8086,
    parameter logic [7:0]  REV     = 8'h01,
    parameter logic [31:0] TICK_FS = 32'd10000000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [WIN_AW-1:0]      bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic [2*DW-1:0]        counter_val,
    output logic                   glb_enable,
    output logic                   glb_legacy,
    output logic [DW-1:0]          ch_wdata,
    output logic [NCH-1:0]         ch_cfg_we,
    output logic [NCH-1:0]         ch_cmp_lo_we,
    output logic [NCH-1:0]         ch_cmp_hi_we,
    output logic [NCH-1:0]         ch_rearm,
    input  logic [NCH*DW-1:0]      ch_cfg_in,
    input  logic [NCH*DW-1:0]      ch_cap_in,
    input  logic [NCH*2*DW-1:0]    ch_cmp_in,
    input  logic [NCH*DW-1:0]      ch_route_in
);
    localparam int CW = 2 * DW;
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), REV};

    typedef struct packed {
        logic           en;
        logic           leg;
        logic [DW-1:0]  rdata;
        logic [NCH-1:0] rearm;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;

    logic [DW-1:0] rd_val;
    logic [CW-1:0] cnt;
    logic [DW-1:0] hi_snap;
    logic [SW-1:0] slot_i;

    logic [DW-1:0] cfg_a   [NCH];
    logic [DW-1:0] cap_a   [NCH];
    logic [CW-1:0] cmp_a   [NCH];
    logic [DW-1:0] route_a [NCH];

    evtmr_decode #(.NCH(NCH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    evtmr_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.en),
        .tick    (tick),
        .wr_lo   (bus_wr && dec.region == RG_CNT_LO),
        .wr_hi   (bus_wr && dec.region == RG_CNT_HI),
        .wdata   (bus_wdata),
        .snap    (bus_rd && dec.region == RG_CNT_LO),
        .count   (cnt),
        .hi_snap (hi_snap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg_a[g]        = ch_cfg_in[g*DW +: DW];
        assign cap_a[g]        = ch_cap_in[g*DW +: DW];
        assign cmp_a[g]        = ch_cmp_in[g*CW +: CW];
        assign route_a[g]      = ch_route_in[g*DW +: DW];
        assign ch_cfg_we[g]    = bus_wr && (dec.region == RG_CH_CFG)    && (dec.slot == 5'(g));
        assign ch_cmp_lo_we[g] = bus_wr && (dec.region == RG_CH_CMP_LO) && (dec.slot == 5'(g));
        assign ch_cmp_hi_we[g] = bus_wr && (dec.region == RG_CH_CMP_HI) && (dec.slot == 5'(g));
    end

    assign slot_i = dec.slot[SW-1:0];

    always_comb begin
        rd_val = '0;
        case (dec.region)
            RG_CAP_LO:    rd_val = CAP_LO;
            RG_CAP_HI:    rd_val = TICK_FS;
            RG_CFG:       rd_val = {{(DW-2){1'b0}}, st_q.leg, st_q.en};
            RG_CNT_LO:    rd_val = cnt[DW-1:0];
            RG_CNT_HI:    rd_val = hi_snap;
            RG_CH_CFG:    rd_val = cfg_a[slot_i];
            RG_CH_CAP:    rd_val = cap_a[slot_i];
            RG_CH_CMP_LO: rd_val = cmp_a[slot_i][DW-1:0];
            RG_CH_CMP_HI: rd_val = cmp_a[slot_i][CW-1:DW];
            RG_CH_ROUTE:  rd_val = route_a[slot_i];
            default:      rd_val = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.rearm = '0;
        if (bus_rd)
            st_d.rdata = rd_val;
        if (bus_wr && dec.region == RG_CFG) begin
            st_d.en  = bus_wdata[0];
            st_d.leg = bus_wdata[1];
            for (int i = 0; i < NCH; i++)
                st_d.rearm[i] = bus_wdata[0] && !st_q.en && (cmp_a[i] != {CW{1'b1}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata   = st_q.rdata;
    assign counter_val = cnt;
    assign glb_enable  = st_q.en;
    assign glb_legacy  = st_q.leg;
    assign ch_wdata    = bus_wdata;
    assign ch_rearm    = st_q.rearm;

    // R7
    rearm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rearm) |-> $rose(glb_enable));
    // R3
    cfg_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.region == RG_CFG) |=> (bus_rdata[DW-1:2] == '0));
    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_cfg_we, ch_cmp_lo_we, ch_cmp_hi_we}));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R10
    stat_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec.region == RG_STAT) |=> $stable({glb_enable, glb_legacy}));
endmodule

// File: tb/evtmr_regs_test.sv
module evtmr_regs_test;
    localparam int NCH = 3;
    localparam int DW  = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n, tick, bus_wr, bus_rd;
    logic [9:0]          bus_addr;
    logic [31:0]         bus_wdata, bus_rdata, ch_wdata;
    logic [63:0]         counter_val;
    logic                glb_enable, glb_legacy;
    logic [NCH-1:0]      ch_cfg_we, ch_cmp_lo_we, ch_cmp_hi_we, ch_rearm;
    logic [NCH*DW-1:0]   ch_cfg_in, ch_cap_in, ch_route_in;
    logic [NCH*64-1:0]   ch_cmp_in;

    evtmr_regs uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .counter_val(counter_val), .glb_enable(glb_enable), .glb_legacy(glb_legacy),
        .ch_wdata(ch_wdata), .ch_cfg_we(ch_cfg_we), .ch_cmp_lo_we(ch_cmp_lo_we),
        .ch_cmp_hi_we(ch_cmp_hi_we), .ch_rearm(ch_rearm), .ch_cfg_in(ch_cfg_in),
        .ch_cap_in(ch_cap_in), .ch_cmp_in(ch_cmp_in), .ch_route_in(ch_route_in)
    );

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_cnt;
    logic [31:0] m_snap, m_rdata;
    logic        m_en, m_leg;
    logic [2:0]  m_rearm;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [9:0] a);
        int slot, sub;
        if (a >= 10'h100) begin
            slot = (int'(a) - 'h100) >> 5;
            sub  = int'(a[4:0]) & 'h1C;
            if (slot >= NCH) return 32'h0;
            case (sub)
                'h00: return ch_cfg_in[slot*32 +: 32];
                'h04: return ch_cap_in[slot*32 +: 32];
                'h08: return ch_cmp_in[slot*64 +: 32];
                'h0C: return ch_cmp_in[slot*64+32 +: 32];
                'h10: return ch_route_in[slot*32 +: 32];
                default: return 32'h0;
            endcase
        end
        case ({a[9:2], 2'b00})
            10'h000: return 32'h8086A201;
            10'h004: return 32'd10000000;
            10'h010: return {30'h0, m_leg, m_en};
            10'h0F0: return m_cnt[31:0];
            10'h0F4: return m_snap;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [9:0] a);
        if (a >= 10'h100) return "R9";
        case ({a[9:2], 2'b00})
            10'h000, 10'h004: return "R2";
            10'h010, 10'h014: return "R3";
            10'h0F0, 10'h0F4: return "R6";
            default:          return "R10";
        endcase
    endfunction

    task automatic cycle(logic wr, logic rd, logic [9:0] a, logic [31:0] wd, logic tk);
        logic [8:0]  exp_stb;
        logic [63:0] ncnt;
        logic [31:0] nsnap, nrd;
        logic        nen, nleg, cntw;
        logic [2:0]  nrearm;
        int          slot;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; tick = tk;
        #1;
        exp_stb = '0;
        if (wr && a >= 10'h100) begin
            slot = (int'(a) - 'h100) >> 5;
            if (slot < NCH) begin
                if (a[4:0] == 5'h00) exp_stb[6+slot] = 1'b1;
                if (a[4:0] == 5'h08) exp_stb[3+slot] = 1'b1;
                if (a[4:0] == 5'h0C) exp_stb[slot]   = 1'b1;
            end
        end
        chk("R8 strobes", {55'h0, ch_cfg_we, ch_cmp_lo_we, ch_cmp_hi_we}, {55'h0, exp_stb});
        if (wr) chk("R8 data", {32'h0, ch_wdata}, {32'h0, wd});
        nrd = m_rdata; nsnap = m_snap; ncnt = m_cnt; nen = m_en; nleg = m_leg;
        nrearm = '0; cntw = 1'b0;
        if (rd) nrd = exp_read(a);
        if (rd && a == 10'h0F0) nsnap = m_cnt[63:32];
        if (wr && a == 10'h0F0) begin ncnt = {m_cnt[63:32], wd}; cntw = 1'b1; end
        else if (wr && a == 10'h0F4) begin ncnt = {wd, m_cnt[31:0]}; cntw = 1'b1; end
        else if (m_en && tk) ncnt = m_cnt + 64'd1;
        if (wr && a == 10'h010) begin
            nen = wd[0]; nleg = wd[1];
            for (int i = 0; i < NCH; i++)
                nrearm[i] = wd[0] && !m_en && (ch_cmp_in[i*64 +: 64] != {64{1'b1}});
        end
        @(posedge clk);
        @(negedge clk);
        m_rdata = nrd; m_snap = nsnap; m_cnt = ncnt; m_en = nen; m_leg = nleg; m_rearm = nrearm;
        chk(rd ? req_of(a) : "R11", {32'h0, bus_rdata}, {32'h0, m_rdata});
        chk(cntw ? "R5" : "R4", counter_val, m_cnt);
        chk("R3 outputs", {62'h0, glb_legacy, glb_enable}, {62'h0, m_leg, m_en});
        chk("R7", {61'h0, ch_rearm}, {61'h0, m_rearm});
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr_(logic [9:0] a, logic [31:0] d); cycle(1'b1, 1'b0, a, d, 1'b0); endtask
    task automatic rd_(logic [9:0] a);                 cycle(1'b0, 1'b1, a, 32'h0, 1'b0); endtask

    function automatic logic [9:0] pick_addr();
        logic [31:0] r;
        r = $urandom;
        case (r[3:0])
            4'd0, 4'd1: return 10'h0F0;
            4'd2:       return 10'h0F4;
            4'd3, 4'd4: return 10'h010;
            4'd5:       return 10'h000;
            4'd6:       return 10'h020;
            4'd7:       return 10'h100 + {r[9:8], 5'h00} + {r[12:10], 2'b00};
            4'd8:       return 10'h004;
            default:    return {r[21:14], 2'b00};
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd4711);
        rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < NCH; i++) begin
            ch_cfg_in[i*32 +: 32]   = 32'hC0F0_0000 | i;
            ch_cap_in[i*32 +: 32]   = 32'h0CA0_0010 | i;
            ch_route_in[i*32 +: 32] = 32'hA0A0_0000 | i;
            ch_cmp_in[i*64 +: 64]   = 64'h1111_2222_3333_4440 | 64'(i);
        end
        m_cnt = '0; m_snap = '0; m_rdata = '0; m_en = 1'b0; m_leg = 1'b0; m_rearm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rdata", {32'h0, bus_rdata}, 64'h0);
        chk("R1 counter", counter_val, 64'h0);
        chk("R1 cfg", {62'h0, glb_legacy, glb_enable}, 64'h0);
        chk("R1 strobes", {52'h0, ch_cfg_we, ch_cmp_lo_we, ch_cmp_hi_we, ch_rearm}, 64'h0);
        @(negedge clk);

        // R2 capability and period, writes ignored
        rd_(10'h000); rd_(10'h004);
        wr_(10'h000, 32'hFFFF_FFFF); wr_(10'h004, 32'h0);
        rd_(10'h000); rd_(10'h004);
        // R3 only two writable bits, upper half zero
        wr_(10'h010, 32'hFFFF_FFFF); rd_(10'h010); rd_(10'h014);
        wr_(10'h010, 32'h0); rd_(10'h010);
        // R4 counter holds while disabled
        repeat (4) cycle(1'b0, 1'b0, 10'h0, 32'h0, 1'b1);
        // R5/R6 carry across halves and capture
        wr_(10'h0F0, 32'hFFFF_FFFE); wr_(10'h0F4, 32'h0000_0005);
        wr_(10'h010, 32'h1);
        repeat (3) cycle(1'b0, 1'b0, 10'h0, 32'h0, 1'b1);
        rd_(10'h0F0);
        cycle(1'b0, 1'b0, 10'h0, 32'h0, 1'b1);
        rd_(10'h0F4);
        cycle(1'b1, 1'b0, 10'h0F0, 32'h1234_5678, 1'b1);
        cycle(1'b1, 1'b0, 10'h0F4, 32'h9ABC_DEF0, 1'b1);
        // R10 status writes have no effect
        wr_(10'h020, 32'hFFFF_FFFF); rd_(10'h020); rd_(10'h0C0); rd_(10'h024);
        // R8 R9 sweep every slot, including unpopulated ones
        for (int s = 0; s < 24; s++) begin
            for (int o = 0; o < 32; o += 4) begin
                rd_(10'(10'h100 + s * 32 + o));
                wr_(10'(10'h100 + s * 32 + o), 32'hDEAD_0000 | 32'(s));
            end
        end
        // R7 re-arm skips an all-ones comparator, only on rising enable
        ch_cmp_in[64 +: 64] = {64{1'b1}};
        wr_(10'h010, 32'h0); wr_(10'h010, 32'h1); wr_(10'h010, 32'h3);
        wr_(10'h010, 32'h2); wr_(10'h010, 32'h3);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[7:0] == 8'd0) begin
                for (int i = 0; i < NCH; i++)
                    ch_cmp_in[i*64 +: 64] = ($urandom % 4 == 0) ? {64{1'b1}} : {$urandom, $urandom};
            end
            cycle(r[8] & r[9], r[10], pick_addr(),
                  (r[11] && r[12]) ? 32'hFFFF_FFFC | 32'(r[14:13]) : $urandom, r[15]);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule